// File: doc/BRIEF.md
# Pin Bank Controller with Per-Pin Event Detection

This block gives a processor control over a bank of general-purpose pins through a small word-addressed register bus. Each pin can be turned into an input or an output. The driven level comes from a value register, and the same register reads back the level each pin currently carries. Every pin also has its own event detector. A detector can sense a high or low level, a rising or falling edge, or both edges. Detected events are latched, masked by an enable register, and merged into one interrupt line.

Three independent bit planes choose the sensing mode of a pin: a sense-kind plane (level or edge), a polarity plane, and a dual-edge plane. The dual-edge plane exists only when the `VERSION` parameter is above 2. Each pin's latch is a two-state machine. EV_IDLE moves to EV_LATCHED on the capture transition, when the detector reports an event. EV_LATCHED returns to EV_IDLE on the acknowledge transition, when software writes a 1 to that pin's clear bit and no new event is present in that cycle. Otherwise it takes the hold transition and stays in EV_LATCHED. Pin inputs pass through a two-flop synchronizer before detection.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset the enable plane is all zeros, every pin is an input (direction plane all ones), the driven value is zero, sense-kind and polarity planes are all ones (rising edge), the dual-edge plane and all latched events are zero, and the interrupt output is low.
- R2: Direction bit 1 makes a pin an input (its output enable low). Direction bit 0 makes it an output: output enable high, driving the matching bit of the value register (word index 0, byte offset 0x00). The direction register is at byte offset 0x04.
- R3: A read returns data on `bus_rdata` one cycle after `bus_rd`. Reading offset 0x00 gives the synchronized pin level for input pins and the driven level for output pins. Reads of offsets above 0x24, of misaligned addresses, and of the clear register (0x14) return zero.
- R4: With sense-kind bit 0 (plane at offset 0x18), a pin latches an event on every cycle its synchronized level equals its polarity bit (plane at offset 0x1C). A latched event stays set after the level goes away.
- R5: With sense-kind bit 1 and dual-edge bit 0, polarity 1 latches rising edges and polarity 0 latches falling edges. A pin change that is stable at a clock edge is visible as a latched event after the third rising clock edge.
- R6: With sense-kind bit 1 and dual-edge bit 1 (plane at offset 0x24), both edges are latched. When `VERSION` is 2 or less, the dual-edge plane reads zero, ignores writes, and never enables dual-edge sensing.
- R7: Writing 1 to a bit of the clear register (offset 0x14) clears that pin's latched event, and a 0 bit has no effect. If an event is detected in the same cycle as the clear, the event stays latched, so a level condition that still holds cannot be cleared.
- R8: The status register (offset 0x0C) shows all latched events. The pending register (offset 0x10) shows latched events whose enable bit (offset 0x08) is set. `irq` is high exactly when any pending bit is set.
- R9: The version register (offset 0x20) reads `VERSION`. Writes to status, pending and version are ignored.
- R10: Register bits at and above `NPINS` read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Driven level per pin |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check the per-pin latch machine:
- a detected event is captured on the next edge;
- a latch is only released by a clear that is not overridden by an event;
- an idle latch never sets on its own.

At top level they check that the interrupt stays low while every enable bit is clear, that direction writes reach the output enables, and that version and unmapped reads return their fixed values. Only the bench scenarios can show the following:
- that each sense mode reacts to the right pin transitions;
- the exact three-edge latency;
- that a held level defeats a clear;
- that the build without dual-edge support stays blind to falling edges in a mode that would otherwise catch them.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    // Word index of each register (byte offset divided by four).
    typedef enum logic [3:0] {
        RG_VALUE = 4'd0,
        RG_DIR   = 4'd1,
        RG_IEN   = 4'd2,
        RG_STAT  = 4'd3,
        RG_PEND  = 4'd4,
        RG_CLR   = 4'd5,
        RG_KIND  = 4'd6,
        RG_POL   = 4'd7,
        RG_VER   = 4'd8,
        RG_BOTH  = 4'd9
    } reg_sel_e;

    localparam int LAST_WORD = 9;

    typedef enum logic {
        EV_IDLE    = 1'b0,
        EV_LATCHED = 1'b1
    } ev_state_e;

endpackage

// File: rtl/pin_sync2.sv
module pin_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end

endmodule

// File: rtl/pin_event_cell.sv
module pin_event_cell
    import pin_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,       // synchronized pin level
    input  logic kind_i,      // 0 level, 1 edge
    input  logic pol_i,       // 1 high/rising, 0 low/falling
    input  logic both_i,      // dual-edge when kind_i is 1
    input  logic clr_i,       // acknowledge strobe
    output logic latched_o
);

    ev_state_e state_q, state_d;
    logic      prev_q;
    logic      rise, fall, ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise = lvl_i & ~prev_q;
    assign fall = ~lvl_i & prev_q;

    always_comb begin
        if (!kind_i)     ev = (lvl_i == pol_i);
        else if (both_i) ev = rise | fall;
        else             ev = pol_i ? rise : fall;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    // next state: capture, hold, acknowledge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:    if (ev) state_d = EV_LATCHED;
            EV_LATCHED: if (clr_i && !ev) state_d = EV_IDLE;
            default:    state_d = EV_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        latched_o = 1'b0;
        unique case (state_q)
            EV_IDLE:    latched_o = 1'b0;
            EV_LATCHED: latched_o = 1'b1;
            default:    latched_o = 1'b0;
        endcase
    end

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> latched_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_o && !clr_i) |=> latched_o);

    p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_o && clr_i && !ev) |=> !latched_o);

    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!latched_o && !ev) |=> !latched_o);

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
    import pin_irq_pkg::*;
#(
    parameter int NPINS   = 32,
    parameter int VERSION = 3,
    parameter int ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    localparam int WIDX_W   = ADDR_W - 2;
    localparam bit HAS_BOTH = (VERSION > 2);

    logic [WIDX_W-1:0] widx;
    logic              aligned, wr_ok;
    logic [NPINS-1:0]  dir_q, val_q, ien_q, kind_q, pol_q, both_q;
    logic [NPINS-1:0]  lvl, view, stat, pend, clr_vec, wbits;
    logic [31:0]       rd_next;

    function automatic logic is_reg(input logic [WIDX_W-1:0] w, input reg_sel_e r);
        return w == WIDX_W'(r);
    endfunction

    function automatic logic [31:0] ext(input logic [NPINS-1:0] v);
        logic [31:0] r;
        r = '0;
        r[NPINS-1:0] = v;
        return r;
    endfunction

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ok   = bus_wr && aligned;
    assign wbits   = bus_wdata[NPINS-1:0];

    pin_sync2 #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            val_q  <= '0;
            ien_q  <= '0;
            kind_q <= '1;
            pol_q  <= '1;
        end else if (wr_ok) begin
            if (is_reg(widx, RG_VALUE)) val_q  <= wbits;
            if (is_reg(widx, RG_DIR))   dir_q  <= wbits;
            if (is_reg(widx, RG_IEN))   ien_q  <= wbits;
            if (is_reg(widx, RG_KIND))  kind_q <= wbits;
            if (is_reg(widx, RG_POL))   pol_q  <= wbits;
        end
    end

    generate
        if (HAS_BOTH) begin : g_both
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                             both_q <= '0;
                else if (wr_ok && is_reg(widx, RG_BOTH)) both_q <= wbits;
            end
        end else begin : g_no_both
            assign both_q = '0;
        end
    endgenerate

    assign clr_vec = (wr_ok && is_reg(widx, RG_CLR)) ? wbits : '0;

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            pin_event_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .lvl_i     (lvl[i]),
                .kind_i    (kind_q[i]),
                .pol_i     (pol_q[i]),
                .both_i    (both_q[i]),
                .clr_i     (clr_vec[i]),
                .latched_o (stat[i])
            );
        end
    endgenerate

    assign view    = (dir_q & lvl) | (~dir_q & val_q);
    assign pend    = stat & ien_q;
    assign irq     = |pend;
    assign pin_out = val_q;
    assign pin_oe  = ~dir_q;

    always_comb begin
        rd_next = '0;
        if (aligned) begin
            if      (is_reg(widx, RG_VALUE)) rd_next = ext(view);
            else if (is_reg(widx, RG_DIR))   rd_next = ext(dir_q);
            else if (is_reg(widx, RG_IEN))   rd_next = ext(ien_q);
            else if (is_reg(widx, RG_STAT))  rd_next = ext(stat);
            else if (is_reg(widx, RG_PEND))  rd_next = ext(pend);
            else if (is_reg(widx, RG_KIND))  rd_next = ext(kind_q);
            else if (is_reg(widx, RG_POL))   rd_next = ext(pol_q);
            else if (is_reg(widx, RG_VER))   rd_next = 32'(VERSION);
            else if (is_reg(widx, RG_BOTH))  rd_next = ext(both_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    p_no_enable_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

    p_dir_to_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_ok && is_reg(widx, RG_DIR)) |-> (pin_oe == ~$past(wbits)));

    p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && (int'(widx) > LAST_WORD)) |-> (bus_rdata == '0));

    p_version_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && aligned && is_reg(widx, RG_VER)) |-> (bus_rdata == 32'(VERSION)));

endmodule

// File: tb/pin_irq_ctrl_bench.sv
`timescale 1ns/1ps
module pin_irq_ctrl_bench;

    localparam int NP = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    addr = '0;
    logic          wr = 1'b0;
    logic [31:0]   wdata = '0;
    logic          rd = 1'b0;
    logic [NP-1:0] gin = '0;

    logic [31:0]   rdata, rdata2;
    logic [NP-1:0] pout, poe, pout2, poe2;
    logic          irq, irq2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    logic [31:0] exp2_q[$];
    logic        chk2_q[$];
    string       tag_q[$];
    logic        rv = 1'b0;

    always #4 clk = ~clk;

    pin_irq_ctrl #(.NPINS(NP), .VERSION(3), .ADDR_W(6)) u_pin_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rd(rd), .bus_rdata(rdata), .pin_in(gin), .pin_out(pout), .pin_oe(poe), .irq(irq)
    );

    pin_irq_ctrl #(.NPINS(NP), .VERSION(2), .ADDR_W(6)) u_pin_irq_ctrl_v2 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rd(rd), .bus_rdata(rdata2), .pin_in(gin), .pin_out(pout2), .pin_oe(poe2), .irq(irq2)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // driver: issues a read and pushes the expected words to the scoreboard
    task automatic bus_read(input logic [5:0] a, input logic [31:0] e, input string tag,
                            input logic c2, input logic [31:0] e2);
        @(negedge clk);
        addr = a; rd = 1'b1;
        exp_q.push_back(e); exp2_q.push_back(e2); chk2_q.push_back(c2); tag_q.push_back(tag);
        @(negedge clk);
        rd = 1'b0;
    endtask

    // monitor: compares read data the cycle after each strobe
    always @(posedge clk) rv <= rd;

    always @(negedge clk) begin
        if (rv) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected read", rdata, 32'h0);
            end else begin
                logic [31:0] e, e2;
                logic c2;
                string t;
                e = exp_q.pop_front(); e2 = exp2_q.pop_front();
                c2 = chk2_q.pop_front(); t = tag_q.pop_front();
                check(rdata == e, t, rdata, e);
                if (c2) check(rdata2 == e2, {t, " v2"}, rdata2, e2);
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        check(poe == '0, "R1 oe", 32'(poe), 32'h0);
        check(irq == 1'b0, "R1 irq", 32'(irq), 32'h0);
        bus_read(6'h04, 32'hFFF, "R1 dir", 1'b0, 0);
        bus_read(6'h08, 32'h0, "R1 enable", 1'b0, 0);
        bus_read(6'h18, 32'hFFF, "R1 kind", 1'b0, 0);
        bus_read(6'h1C, 32'hFFF, "R1 polarity", 1'b0, 0);
        bus_read(6'h24, 32'h0, "R1 both", 1'b0, 0);
        bus_read(6'h0C, 32'h0, "R1 status", 1'b1, 32'h0);
        bus_read(6'h20, 32'h3, "R9 version", 1'b1, 32'h2);

        // R2 direction and driven value
        bus_write(6'h04, 32'hFF0);
        check(poe == 12'h00F, "R2 oe", 32'(poe), 32'h00F);
        bus_write(6'h00, 32'h5);
        check(pout[3:0] == 4'h5, "R2 out", 32'(pout[3:0]), 32'h5);

        // R5 rising edges on pins 5 and 7; R3 mixed read-back
        gin = 12'h0A0;
        wait_cyc(4);
        bus_read(6'h00, 32'h0A5, "R3 value", 1'b0, 0);
        bus_read(6'h0C, 32'h0A0, "R5 rising status", 1'b1, 32'h0A0);
        check(irq == 1'b0, "R8 masked", 32'(irq), 32'h0);

        // R8 pending and irq
        bus_write(6'h08, 32'h020);
        check(irq == 1'b1, "R8 irq", 32'(irq), 32'h1);
        bus_read(6'h10, 32'h020, "R8 pending", 1'b0, 0);

        // R7 clear semantics
        bus_write(6'h14, 32'h0);
        bus_read(6'h0C, 32'h0A0, "R7 zero clear", 1'b0, 0);
        bus_write(6'h14, 32'h0A0);
        bus_read(6'h0C, 32'h0, "R7 clear", 1'b0, 0);
        check(irq == 1'b0, "R7 irq after clear", 32'(irq), 32'h0);

        // R5 falling edge on pin 5 with exact latency
        bus_write(6'h1C, 32'hFDF);
        @(negedge clk);
        gin = 12'h080;
        wait_cyc(2);
        check(irq == 1'b0, "R5 latency early", 32'(irq), 32'h0);
        wait_cyc(1);
        check(irq == 1'b1, "R5 latency third edge", 32'(irq), 32'h1);
        bus_write(6'h14, 32'h020);
        check(irq == 1'b0, "R5 clear", 32'(irq), 32'h0);

        // R4 level sensing on pin 6
        bus_write(6'h18, 32'hFBF);
        bus_write(6'h08, 32'h040);
        check(irq == 1'b0, "R4 no level", 32'(irq), 32'h0);
        gin = 12'h0C0;
        wait_cyc(4);
        check(irq == 1'b1, "R4 level high", 32'(irq), 32'h1);
        bus_write(6'h14, 32'h040);
        wait_cyc(2);
        check(irq == 1'b1, "R7 level blocks clear", 32'(irq), 32'h1);
        gin = 12'h080;
        wait_cyc(4);
        check(irq == 1'b1, "R4 stays latched", 32'(irq), 32'h1);
        bus_write(6'h14, 32'h040);
        check(irq == 1'b0, "R7 clear after level", 32'(irq), 32'h0);
        bus_write(6'h1C, 32'hF9F);
        wait_cyc(2);
        check(irq == 1'b1, "R4 level low", 32'(irq), 32'h1);
        bus_write(6'h1C, 32'hFDF);
        bus_write(6'h14, 32'h040);
        check(irq == 1'b0, "R4 clear low", 32'(irq), 32'h0);

        // R6 dual edge on pin 8
        bus_write(6'h18, 32'hFFF);
        bus_write(6'h24, 32'h100);
        bus_write(6'h08, 32'h100);
        gin = 12'h180;
        wait_cyc(4);
        check(irq == 1'b1, "R6 rise", 32'(irq), 32'h1);
        check(irq2 == 1'b1, "R6 rise v2", 32'(irq2), 32'h1);
        bus_write(6'h14, 32'h100);
        check(irq == 1'b0, "R6 clear", 32'(irq), 32'h0);
        gin = 12'h080;
        wait_cyc(4);
        check(irq == 1'b1, "R6 fall", 32'(irq), 32'h1);
        check(irq2 == 1'b0, "R6 fall v2 ignored", 32'(irq2), 32'h0);
        bus_read(6'h24, 32'h100, "R6 both reg", 1'b1, 32'h0);
        bus_write(6'h14, 32'h100);

        // R9 read-only registers, R3 unmapped, R10 upper bits
        bus_write(6'h0C, 32'hFFF);
        bus_read(6'h0C, 32'h0, "R9 status write ignored", 1'b1, 32'h0);
        bus_write(6'h10, 32'hFFF);
        bus_read(6'h10, 32'h0, "R9 pending write ignored", 1'b0, 0);
        bus_write(6'h20, 32'h55);
        bus_read(6'h20, 32'h3, "R9 version write ignored", 1'b1, 32'h2);
        bus_read(6'h28, 32'h0, "R3 unmapped 0x28", 1'b0, 0);
        bus_read(6'h3C, 32'h0, "R3 unmapped 0x3C", 1'b0, 0);
        bus_read(6'h05, 32'h0, "R3 misaligned", 1'b0, 0);
        bus_read(6'h14, 32'h0, "R3 clear reads zero", 1'b0, 0);
        bus_write(6'h04, 32'hFFFFFFFF);
        bus_read(6'h04, 32'hFFF, "R10 dir upper bits", 1'b0, 0);
        bus_write(6'h08, 32'hFFFFF000);
        bus_read(6'h08, 32'h0, "R10 enable upper bits", 1'b0, 0);
        check(irq == 1'b0, "R10 irq", 32'(irq), 32'h0);

        wait_cyc(3);
        check(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule